// File: doc/BRIEF.md
# Address and Opcode Match Event Filter

This block watches a stream of incoming transaction requests and raises an event for each one whose fields agree with a programmable 64-bit match word. Each request carries three fields: a 40-bit physical address, a 4-bit header opcode and a 4-bit message class. The address is compared at 8-byte granularity, so the low three address bits never take part. Three one-hot select bits in the top of the match word choose which of the three comparisons are enabled. A request matches only when every enabled comparison is equal.

Each matching request yields a one-cycle event pulse. A 48-bit counter counts these pulses, but only while the counter's 8-bit event-select input holds the match-event code. The match word is written through a simple write strobe and can always be read back. Reserved bits read back as zero.

Top module: `txn_match_filter`

## Requirements
- R1: While reset is active and after it is released, `cfg_rdata`, `count` and `hit_evt` are all zero.
- R2: A write with `cfg_we` high stores only the defined bits of `cfg_wdata`: bits 63:61, 47:44, 43:40 and 39:3. Reserved bits 60:48 and 2:0 always read back as zero. Writing all ones therefore reads back as 0xE000_FFFF_FFFF_FFF8.
- R3: Bit 61 of the match word enables the address comparison. That comparison checks `txn_addr[39:3]` against match bits 39:3 and ignores `txn_addr[2:0]`.
- R4: Bit 62 enables the opcode comparison of `txn_opc` against match bits 43:40.
- R5: Bit 63 enables the message-class comparison of `txn_cls` against match bits 47:44.
- R6: When several select bits are set, a request matches only if every enabled comparison is equal.
- R7: When select bits 63:61 are all zero, no request matches, whatever its fields.
- R8: `hit_evt` is high for exactly the one cycle after each cycle in which `txn_valid` is high and the request matches. It stays low after a cycle with `txn_valid` low. Back-to-back matching requests give one pulse each.
- R9: `count` advances by one, at the same clock edge that raises `hit_evt`, for each matching valid request. This happens only when `evt_sel` equals the match-event code (default 0x35). With any other `evt_sel` value, `count` holds while `hit_evt` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the match word |
| cfg_wdata | input | 64 | Match word write data |
| cfg_rdata | output | 64 | Current match word, with reserved bits zero |
| evt_sel | input | 8 | Counter event-select code |
| txn_valid | input | 1 | Request present this cycle |
| txn_addr | input | 40 | Request physical address |
| txn_opc | input | 4 | Request header opcode |
| txn_cls | input | 4 | Request message class |
| hit_evt | output | 1 | One-cycle match event pulse |
| count | output | 48 | Filtered event count |

## Verification
The assertions check several properties on every cycle. Reserved bits of the match word stay zero. No pulse follows an invalid cycle or an empty select field. An address-only match with equal upper address bits always pulses. The count moves by exactly the gated pulse and holds under a foreign event code. The bench's scenarios show the rest: the stored value of each field after a write, the effect of the low address bits, the opcode and class comparisons alone and combined, and the accumulated count over back-to-back requests.

// File: rtl/txn_match_pkg.sv
package txn_match_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 40;
  localparam int ADDR_LSB = 3;
  localparam int NIB_W    = 4;
  localparam int OPC_LO   = ADDR_W;
  localparam int OPC_HI   = OPC_LO + NIB_W - 1;
  localparam int CLS_LO   = OPC_HI + 1;
  localparam int CLS_HI   = CLS_LO + NIB_W - 1;
  localparam int SEL_N    = 3;
  localparam int SEL_LO   = REG_W - SEL_N;

  typedef enum int {
    FLD_ADDR = 0,
    FLD_OPC  = 1,
    FLD_CLS  = 2
  } fld_e;

  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++) begin
      m[b] = ((b >= ADDR_LSB) && (b <= CLS_HI)) || (b >= SEL_LO);
    end
    return m;
  endfunction
endpackage

// File: rtl/match_cfg_reg.sv
module match_cfg_reg
  import txn_match_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] KEEP = keep_mask();

  logic [REG_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wdata & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/field_cmp.sv
module field_cmp
  import txn_match_pkg::*;
(
  input  logic [REG_W-1:0]  cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  opc,
  input  logic [NIB_W-1:0]  cls,
  output logic              match
);
  logic [SEL_N-1:0] eq;
  logic [SEL_N-1:0] sel;

  assign sel = cfg[REG_W-1:SEL_LO];

  for (genvar i = 0; i < SEL_N; i++) begin : g_fld
    if (i == FLD_ADDR) begin : g_addr
      assign eq[i] = (addr[ADDR_W-1:ADDR_LSB] == cfg[ADDR_W-1:ADDR_LSB]);
    end else if (i == FLD_OPC) begin : g_opc
      assign eq[i] = (opc == cfg[OPC_HI:OPC_LO]);
    end else begin : g_cls
      assign eq[i] = (cls == cfg[CLS_HI:CLS_LO]);
    end
  end

  assign match = (|sel) && (&(eq | ~sel));
endmodule

// File: rtl/event_counter.sv
module event_counter #(
  parameter int              CNT_W    = 48,
  parameter int              EVT_W    = 8,
  parameter logic [EVT_W-1:0] EVT_CODE = 8'h35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [EVT_W-1:0] evt_sel,
  output logic             pulse,
  output logic [CNT_W-1:0] cnt
);
  logic             pulse_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    pulse_nxt = fire;
    cnt_en    = fire && (evt_sel == EVT_CODE);
    cnt_nxt   = cnt;
    if (cnt_en) cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      cnt   <= '0;
    end else begin
      pulse <= pulse_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/txn_match_filter.sv
module txn_match_filter
  import txn_match_pkg::*;
#(
  parameter int               CNT_W    = 48,
  parameter int               EVT_W    = 8,
  parameter logic [EVT_W-1:0] EVT_CODE = 8'h35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic [EVT_W-1:0]  evt_sel,
  input  logic              txn_valid,
  input  logic [39:0]       txn_addr,
  input  logic [3:0]        txn_opc,
  input  logic [3:0]        txn_cls,
  output logic              hit_evt,
  output logic [CNT_W-1:0]  count
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [REG_W-1:0] cfg_q;
  logic             fld_match;
  logic             fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  match_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  field_cmp u_cmp (
    .cfg   (cfg_q),
    .addr  (txn_addr),
    .opc   (txn_opc),
    .cls   (txn_cls),
    .match (fld_match)
  );

  assign fire = txn_valid && fld_match;

  event_counter #(
    .CNT_W    (CNT_W),
    .EVT_W    (EVT_W),
    .EVT_CODE (EVT_CODE)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .fire    (fire),
    .evt_sel (evt_sel),
    .pulse   (hit_evt),
    .cnt     (count)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/txn_match_chk.sv
module txn_match_chk #(
  parameter int               CNT_W    = 48,
  parameter int               EVT_W    = 8,
  parameter logic [EVT_W-1:0] EVT_CODE = 8'h35
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      cfg_rdata,
  input logic [EVT_W-1:0] evt_sel,
  input logic             txn_valid,
  input logic [39:0]      txn_addr,
  input logic             hit_evt,
  input logic [CNT_W-1:0] count
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[60:48] == '0) && (cfg_rdata[2:0] == '0));

  assert_addr_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && cfg_rdata[63:61] == 3'b001 && txn_addr[39:3] == cfg_rdata[39:3])
    |=> hit_evt);

  assert_empty_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[63:61] == 3'b000) |=> !hit_evt);

  assert_no_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_valid |=> !hit_evt);

  assert_hold_foreign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sel != EVT_CODE) |=> $stable(count));

  assert_step_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sel == EVT_CODE) |=> (count == $past(count) + CNT_W'(hit_evt)));
endmodule

bind txn_match_filter txn_match_chk #(
  .CNT_W    (CNT_W),
  .EVT_W    (EVT_W),
  .EVT_CODE (EVT_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .evt_sel   (evt_sel),
  .txn_valid (txn_valid),
  .txn_addr  (txn_addr),
  .hit_evt   (hit_evt),
  .count     (count)
);

// File: tb/test_txn_match_filter.sv
module test_txn_match_filter;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic [7:0]  evt_sel;
  logic        txn_valid;
  logic [39:0] txn_addr;
  logic [3:0]  txn_opc;
  logic [3:0]  txn_cls;
  logic        hit_evt;
  logic [47:0] count;

  int total = 0;
  int bad   = 0;
  logic [47:0] exp_cnt = '0;

  txn_match_filter i_txn_match_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .evt_sel(evt_sel), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_opc(txn_opc), .txn_cls(txn_cls),
    .hit_evt(hit_evt), .count(count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [63:0] cfg;
    logic [39:0] addr;
    logic [3:0]  opc;
    logic [3:0]  cls;
    logic        hit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{64'h2000_0012_3456_7890, 40'h12_3456_7890, 4'h0, 4'h0, 1'b1}, // R3
    '{64'h2000_0012_3456_7890, 40'h12_3456_7897, 4'h0, 4'h0, 1'b1}, // R3 low bits ignored
    '{64'h2000_0012_3456_7890, 40'h12_3456_7898, 4'h0, 4'h0, 1'b0}, // R3 bit 3 differs
    '{64'h4000_0500_0000_0000, 40'hFF_0000_0000, 4'h5, 4'h9, 1'b1}, // R4
    '{64'h4000_0500_0000_0000, 40'h00_0000_0000, 4'h6, 4'h0, 1'b0}, // R4
    '{64'h8000_A000_0000_0000, 40'h00_0000_0008, 4'h0, 4'hA, 1'b1}, // R5
    '{64'h8000_A000_0000_0000, 40'h00_0000_0000, 4'h0, 4'hB, 1'b0}, // R5
    '{64'hE000_A500_0000_1000, 40'h00_0000_1000, 4'h5, 4'hA, 1'b1}, // R6
    '{64'hE000_A500_0000_1000, 40'h00_0000_1000, 4'h4, 4'hA, 1'b0}, // R6
    '{64'hE000_A500_0000_1000, 40'h00_0000_1008, 4'h5, 4'hA, 1'b0}, // R6
    '{64'h0000_0000_0000_0000, 40'h00_0000_0000, 4'h0, 4'h0, 1'b0}  // R7
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic write_cfg(input logic [63:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; evt_sel = 8'h35;
    txn_valid = 1'b0; txn_addr = '0; txn_opc = '0; txn_cls = '0;
    repeat (3) @(negedge clk);
    chk("R1 cfg in reset", cfg_rdata, 64'h0);
    chk("R1 count in reset", 64'(count), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cfg after reset", cfg_rdata, 64'h0);
    chk("R1 hit after reset", 64'(hit_evt), 64'h0);
    chk("R1 count after reset", 64'(count), 64'h0);

    write_cfg(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 reserved masked", cfg_rdata, 64'hE000_FFFF_FFFF_FFF8);

    for (int i = 0; i < NV; i++) begin
      write_cfg(TBL[i].cfg);
      txn_valid = 1'b1; txn_addr = TBL[i].addr;
      txn_opc = TBL[i].opc; txn_cls = TBL[i].cls;
      @(negedge clk);
      txn_valid = 1'b0;
      if (TBL[i].hit) exp_cnt = exp_cnt + 48'd1;
      chk($sformatf("R3-R7 vec%0d hit", i), 64'(hit_evt), 64'(TBL[i].hit));
      chk($sformatf("R9 vec%0d count", i), 64'(count), 64'(exp_cnt));
    end

    // R8: valid low with matching fields gives no pulse
    write_cfg(64'h2000_0000_0000_0040);
    txn_addr = 40'h40; txn_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle no hit", 64'(hit_evt), 64'h0);
    chk("R8 idle no count", 64'(count), 64'(exp_cnt));

    // R8: back-to-back matches, one pulse each
    txn_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      exp_cnt = exp_cnt + 48'd1;
      chk($sformatf("R8 burst hit %0d", k), 64'(hit_evt), 64'h1);
      chk($sformatf("R9 burst count %0d", k), 64'(count), 64'(exp_cnt));
    end
    txn_valid = 1'b0;
    @(negedge clk);
    chk("R8 pulse ends", 64'(hit_evt), 64'h0);

    // R9: foreign event code holds count, pulse still seen
    evt_sel = 8'h34; txn_valid = 1'b1;
    @(negedge clk);
    txn_valid = 1'b0;
    chk("R9 foreign code hit", 64'(hit_evt), 64'h1);
    chk("R9 foreign code holds", 64'(count), 64'(exp_cnt));
    evt_sel = 8'h35;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule